// File: doc/BRIEF.md
# I2C Register-Addressed Transaction Controller

This block runs complete memory-style I2C transactions (device probe, register read, register write) by issuing a stream of bus-level commands to a separate bit engine. The engine handles bit timing, bus recovery and arbitration. It takes one command at a time (START, STOP, write a byte, read a byte) and answers each with a completion pulse. That pulse carries the slave's ACK/NACK for a written byte, or the byte it received.

A request holds a 7-bit device address, a register address of zero to three bytes, a byte count and an opcode. Write payload comes in through a valid/ready byte stream, and read payload leaves through another. Two options are set per request. The first picks a repeated START or a STOP-then-START before the read phase. The second folds register-address bits above the transmitted bytes into the device address under a mask, so that a memory with 9 to 11 address bits looks like several 256-byte devices. When the request finishes, a one-cycle done pulse is raised. A status code and a count of NACKed write-data bytes are held until the next request is accepted.

Top module: `i2c_xact_ctrl`

## Requirements
- R1: After reset the block is idle: req_ready is 1, eng_cmd_valid, rd_valid and done are 0, status is 0 and fail_cnt is 0.
- R2: A probe (req_op 0, and also 3) issues START, WRITE of {dev,0}, STOP. status is 0 when the address byte is ACKed and 1 (no device) when it is NACKed.
- R3: Register address bytes are sent most significant first, and exactly req_alen of them (0..3) are sent. The bytes come from the low 8*req_alen bits of req_reg.
- R4: A read (req_op 1) with req_alen > 0 sends START, WRITE {dev,0}, then the register bytes. It then sends STOP followed by START when cfg_rep_start is 0, or START alone when it is 1, and then WRITE {dev,1}.
- R5: A read with req_alen of 0 sends START then WRITE {dev,1} directly, with no write-mode phase.
- R6: A read returns req_len bytes on rd_data in the order received. Every READ command except the last has eng_mack=1 (master ACK); the last has eng_mack=0. STOP follows, and status is 0.
- R7: If the write-mode device address is NACKed during a read or write, STOP is issued at once and status is 1.
- R8: If a register address byte is NACKed, no further bytes are sent, STOP is issued and status is 2.
- R9: A write (req_op 2) pulls req_len bytes from the write stream and sends each. A NACKed data byte does not stop the transfer. fail_cnt equals the number of NACKed data bytes after the final STOP, and status is 0.
- R10: For reads and writes with cfg_ovf_en=1, the device address sent is req_dev OR ((req_reg >> 8*req_alen) & cfg_ovf_mask), taking bits 6..0. Probes are not folded.
- R11: Engine opcodes are 0 START, 1 STOP, 2 WRITE, 3 READ. A command and its fields stay stable until eng_cmd_ready. Only one command is outstanding until eng_done. rd_data stays stable while rd_valid waits for rd_ready.
- R12: A request is accepted only while req_ready is 1 (idle). done pulses for one cycle after the final STOP completes. status and fail_cnt hold their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request taken |
| req_op | input | 2 | 0 probe, 1 read, 2 write, 3 probe |
| req_dev | input | 7 | Device address |
| req_reg | input | 24 | Register address, low bytes used |
| req_alen | input | 2 | Register address length in bytes |
| req_len | input | 8 | Data byte count |
| cfg_rep_start | input | 1 | 1: repeated START before read phase |
| cfg_ovf_en | input | 1 | Enable address overflow folding |
| cfg_ovf_mask | input | 3 | Mask on folded bits |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| eng_cmd_valid | output | 1 | Command to engine |
| eng_cmd_ready | input | 1 | Engine takes command |
| eng_op | output | 2 | Command opcode |
| eng_wbyte | output | 8 | Byte for WRITE |
| eng_mack | output | 1 | 1: master ACKs after READ |
| eng_done | input | 1 | Command completion pulse |
| eng_nack | input | 1 | Slave NACK on WRITE |
| eng_rbyte | input | 8 | Byte from READ |
| done | output | 1 | Transaction finished pulse |
| status | output | 2 | 0 ok, 1 no device, 2 address error |
| fail_cnt | output | 8 | NACKed write data bytes |

## Verification
The assertions check the handshake rules on every cycle. A pending engine command and a pending read byte must hold still, and nothing is issued while idle. Results must stay put between requests, and done must be a single-cycle pulse. The order of bus commands (address byte order, the choice of mid-read restart, skipping the write phase, master ACK versus NACK on the final byte) can be shown only by the bench's scenarios. The same holds for the error exits and the failure count, and for the folded device address. The bench logs every command a modelled engine accepts and compares the log against the sequence each requirement dictates.

// File: rtl/i2c_xact_pkg.sv
package i2c_xact_pkg;
  typedef enum logic [1:0] {
    ENG_START = 2'd0,
    ENG_STOP  = 2'd1,
    ENG_WRITE = 2'd2,
    ENG_READ  = 2'd3
  } eng_op_t;

  typedef enum logic [1:0] {
    REQ_PROBE = 2'd0,
    REQ_READ  = 2'd1,
    REQ_WRITE = 2'd2,
    REQ_ALT   = 2'd3
  } req_op_t;

  typedef enum logic [1:0] {
    STAT_OK    = 2'd0,
    STAT_NODEV = 2'd1,
    STAT_ADDR  = 2'd2
  } stat_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_DEVW, ST_REG, ST_MIDSTOP, ST_RESTART,
    ST_DEVR, ST_RDBYTE, ST_RDPUSH, ST_WRPULL, ST_WRBYTE, ST_STOP
  } seq_state_t;
endpackage

// File: rtl/i2c_xact_fold.sv
module i2c_xact_fold #(
  parameter int ALEN_W = 2,
  parameter int RA_W   = 24,
  parameter int MASK_W = 3
) (
  input  logic [6:0]        dev_in,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [ALEN_W-1:0] alen,
  input  logic              ovf_en,
  input  logic [MASK_W-1:0] ovf_mask,
  output logic [6:0]        dev_out
);
  localparam int SH_W = ALEN_W + 3;

  logic [SH_W-1:0] shamt;
  logic [RA_W-1:0] upper;
  logic [6:0]      mask_ext;

  assign shamt    = {alen, 3'b000};
  assign upper    = reg_addr >> shamt;
  assign mask_ext = 7'(ovf_mask);
  assign dev_out  = ovf_en ? (dev_in | (upper[6:0] & mask_ext)) : dev_in;

  logic unused_upper;
  assign unused_upper = ^upper;
endmodule

// File: rtl/i2c_xact_seq.sv
module i2c_xact_seq
  import i2c_xact_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int ALEN_W = 2,
  parameter int RA_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [6:0]        req_dev,
  input  logic [6:0]        fold_dev,
  input  logic [RA_W-1:0]   req_reg,
  input  logic [ALEN_W-1:0] req_alen,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              cfg_rep_start,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              eng_cmd_valid,
  input  logic              eng_cmd_ready,
  output logic [1:0]        eng_op,
  output logic [7:0]        eng_wbyte,
  output logic              eng_mack,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic [7:0]        eng_rbyte,
  output logic              done,
  output logic [1:0]        status,
  output logic [LEN_W-1:0]  fail_cnt
);
  localparam int SH_W = ALEN_W + 3;

  seq_state_t        state_q, state_d;
  req_op_t           op_q, op_d;
  logic [6:0]        dev_q, dev_d;
  logic [RA_W-1:0]   reg_q, reg_d;
  logic [ALEN_W-1:0] alen_q, alen_d;
  logic [ALEN_W-1:0] ridx_q, ridx_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic              rep_q, rep_d;
  logic              wait_q, wait_d;
  logic [7:0]        byte_q, byte_d;
  stat_t             stat_q, stat_d;
  logic [LEN_W-1:0]  fail_q, fail_d;
  logic              done_q, done_d;

  logic              is_cmd;
  eng_op_t           cmd_op;
  logic [7:0]        cmd_byte;
  logic              cmd_mack;
  logic              fire;
  logic              accept;
  logic [RA_W-1:0]   reg_shift;
  logic [SH_W-1:0]   reg_shamt;
  seq_state_t        post_addr;

  assign reg_shamt = {ridx_q, 3'b000};
  assign reg_shift = reg_q >> reg_shamt;

  // Command decode per state
  always_comb begin
    is_cmd   = 1'b1;
    cmd_op   = ENG_START;
    cmd_byte = 8'h00;
    cmd_mack = 1'b0;
    unique case (state_q)
      ST_START, ST_RESTART: cmd_op = ENG_START;
      ST_MIDSTOP, ST_STOP:  cmd_op = ENG_STOP;
      ST_DEVW: begin cmd_op = ENG_WRITE; cmd_byte = {dev_q, 1'b0}; end
      ST_DEVR: begin cmd_op = ENG_WRITE; cmd_byte = {dev_q, 1'b1}; end
      ST_REG:  begin cmd_op = ENG_WRITE; cmd_byte = reg_shift[7:0]; end
      ST_WRBYTE: begin cmd_op = ENG_WRITE; cmd_byte = byte_q; end
      ST_RDBYTE: begin cmd_op = ENG_READ; cmd_mack = (cnt_q != LEN_W'(1)); end
      default: is_cmd = 1'b0;
    endcase
  end

  assign accept = req_valid && (state_q == ST_IDLE);
  assign fire   = wait_q && eng_done;

  // Where to go once the register address phase is over
  always_comb begin
    if (op_q == REQ_READ) post_addr = rep_q ? ST_RESTART : ST_MIDSTOP;
    else if (cnt_q == '0) post_addr = ST_STOP;
    else                  post_addr = ST_WRPULL;
  end

  always_comb begin
    state_d = state_q; op_d = op_q; dev_d = dev_q; reg_d = reg_q;
    alen_d = alen_q; ridx_d = ridx_q; cnt_d = cnt_q; rep_d = rep_q;
    wait_d = wait_q; byte_d = byte_q; stat_d = stat_q; fail_d = fail_q;
    done_d = 1'b0;

    if (is_cmd && !wait_q && eng_cmd_ready) wait_d = 1'b1;
    if (fire) wait_d = 1'b0;

    unique case (state_q)
      ST_IDLE: if (accept) begin
        op_d    = req_op_t'(req_op);
        dev_d   = (req_op == REQ_READ || req_op == REQ_WRITE) ? fold_dev : req_dev;
        reg_d   = req_reg;
        alen_d  = req_alen;
        cnt_d   = req_len;
        rep_d   = cfg_rep_start;
        stat_d  = STAT_OK;
        fail_d  = '0;
        state_d = ST_START;
      end
      ST_START: if (fire) begin
        if (op_q == REQ_READ && alen_q == '0) state_d = ST_DEVR;
        else                                  state_d = ST_DEVW;
      end
      ST_DEVW: if (fire) begin
        if (eng_nack) begin
          stat_d  = STAT_NODEV;
          state_d = ST_STOP;
        end else if (op_q != REQ_READ && op_q != REQ_WRITE) begin
          state_d = ST_STOP;
        end else if (alen_q != '0) begin
          ridx_d  = alen_q - ALEN_W'(1);
          state_d = ST_REG;
        end else begin
          state_d = post_addr;
        end
      end
      ST_REG: if (fire) begin
        if (eng_nack) begin
          stat_d  = STAT_ADDR;
          state_d = ST_STOP;
        end else if (ridx_q == '0) begin
          state_d = post_addr;
        end else begin
          ridx_d = ridx_q - ALEN_W'(1);
        end
      end
      ST_MIDSTOP: if (fire) state_d = ST_RESTART;
      ST_RESTART: if (fire) state_d = ST_DEVR;
      ST_DEVR: if (fire) state_d = (cnt_q == '0) ? ST_STOP : ST_RDBYTE;
      ST_RDBYTE: if (fire) begin
        byte_d  = eng_rbyte;
        state_d = ST_RDPUSH;
      end
      ST_RDPUSH: if (rd_ready) begin
        cnt_d   = cnt_q - LEN_W'(1);
        state_d = (cnt_q == LEN_W'(1)) ? ST_STOP : ST_RDBYTE;
      end
      ST_WRPULL: if (wr_valid) begin
        byte_d  = wr_data;
        state_d = ST_WRBYTE;
      end
      ST_WRBYTE: if (fire) begin
        if (eng_nack) fail_d = fail_q + LEN_W'(1);
        cnt_d   = cnt_q - LEN_W'(1);
        state_d = (cnt_q == LEN_W'(1)) ? ST_STOP : ST_WRPULL;
      end
      ST_STOP: if (fire) begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; op_q <= REQ_PROBE; dev_q <= '0; reg_q <= '0;
      alen_q <= '0; ridx_q <= '0; cnt_q <= '0; rep_q <= 1'b0;
      wait_q <= 1'b0; byte_q <= '0; stat_q <= STAT_OK; fail_q <= '0;
      done_q <= 1'b0;
    end else begin
      state_q <= state_d; op_q <= op_d; dev_q <= dev_d; reg_q <= reg_d;
      alen_q <= alen_d; ridx_q <= ridx_d; cnt_q <= cnt_d; rep_q <= rep_d;
      wait_q <= wait_d; byte_q <= byte_d; stat_q <= stat_d; fail_q <= fail_d;
      done_q <= done_d;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign wr_ready      = (state_q == ST_WRPULL);
  assign rd_valid      = (state_q == ST_RDPUSH);
  assign rd_data       = byte_q;
  assign eng_cmd_valid = is_cmd && !wait_q;
  assign eng_op        = cmd_op;
  assign eng_wbyte     = cmd_byte;
  assign eng_mack      = cmd_mack;
  assign done          = done_q;
  assign status        = stat_q;
  assign fail_cnt      = fail_q;
endmodule

// File: rtl/i2c_xact_ctrl.sv
module i2c_xact_ctrl #(
  parameter int LEN_W    = 8,
  parameter int ALEN_MAX = 3,
  parameter int MASK_W   = 3,
  localparam int RA_W    = 8 * ALEN_MAX,
  localparam int ALEN_W  = $clog2(ALEN_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [6:0]        req_dev,
  input  logic [RA_W-1:0]   req_reg,
  input  logic [ALEN_W-1:0] req_alen,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              cfg_rep_start,
  input  logic              cfg_ovf_en,
  input  logic [MASK_W-1:0] cfg_ovf_mask,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              eng_cmd_valid,
  input  logic              eng_cmd_ready,
  output logic [1:0]        eng_op,
  output logic [7:0]        eng_wbyte,
  output logic              eng_mack,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic [7:0]        eng_rbyte,
  output logic              done,
  output logic [1:0]        status,
  output logic [LEN_W-1:0]  fail_cnt
);
  logic [6:0] fold_dev;

  i2c_xact_fold #(.ALEN_W(ALEN_W), .RA_W(RA_W), .MASK_W(MASK_W)) u_fold (
    .dev_in(req_dev), .reg_addr(req_reg), .alen(req_alen),
    .ovf_en(cfg_ovf_en), .ovf_mask(cfg_ovf_mask), .dev_out(fold_dev)
  );

  i2c_xact_seq #(.LEN_W(LEN_W), .ALEN_W(ALEN_W), .RA_W(RA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_dev(req_dev), .fold_dev(fold_dev), .req_reg(req_reg),
    .req_alen(req_alen), .req_len(req_len), .cfg_rep_start(cfg_rep_start),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd_ready(eng_cmd_ready),
    .eng_op(eng_op), .eng_wbyte(eng_wbyte), .eng_mack(eng_mack),
    .eng_done(eng_done), .eng_nack(eng_nack), .eng_rbyte(eng_rbyte),
    .done(done), .status(status), .fail_cnt(fail_cnt)
  );
endmodule

// File: rtl/i2c_xact_chk.sv
module i2c_xact_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             eng_cmd_valid,
  input logic             eng_cmd_ready,
  input logic [1:0]       eng_op,
  input logic [7:0]       eng_wbyte,
  input logic             eng_mack,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [7:0]       rd_data,
  input logic             done,
  input logic [1:0]       status,
  input logic [LEN_W-1:0] fail_cnt
);
  p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid && !eng_cmd_ready |=>
      eng_cmd_valid && $stable(eng_op) && $stable(eng_wbyte) && $stable(eng_mack));

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !eng_cmd_valid && !rd_valid);

  p_result_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && !req_valid |=> $stable(status) && $stable(fail_cnt));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  p_status_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'd3);
endmodule

bind i2c_xact_ctrl i2c_xact_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .eng_cmd_valid(eng_cmd_valid), .eng_cmd_ready(eng_cmd_ready),
  .eng_op(eng_op), .eng_wbyte(eng_wbyte), .eng_mack(eng_mack),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .done(done), .status(status), .fail_cnt(fail_cnt)
);

// File: tb/tb_i2c_xact_ctrl.sv
module tb_i2c_xact_ctrl;
  localparam int S = 0, P = 1, W = 2, R = 3;

  logic clk, rst_n;
  logic req_valid, req_ready;
  logic [1:0] req_op;
  logic [6:0] req_dev;
  logic [23:0] req_reg;
  logic [1:0] req_alen;
  logic [7:0] req_len;
  logic cfg_rep_start, cfg_ovf_en;
  logic [2:0] cfg_ovf_mask;
  logic wr_valid, wr_ready;
  logic [7:0] wr_data;
  logic rd_valid, rd_ready;
  logic [7:0] rd_data;
  logic eng_cmd_valid, eng_cmd_ready;
  logic [1:0] eng_op;
  logic [7:0] eng_wbyte;
  logic eng_mack, eng_done, eng_nack;
  logic [7:0] eng_rbyte;
  logic done;
  logic [1:0] status;
  logic [7:0] fail_cnt;

  i2c_xact_ctrl dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;

  // engine model state and command log
  logic [10:0] log_e [64];
  logic [10:0] exp_e [64];
  int log_n, exp_n, wn, rn, pend, wi;
  logic [63:0] nack_mask;
  logic [7:0] rd_base;
  logic [7:0] rd_got [16];
  int rd_n;
  logic [7:0] wsrc [8];
  logic stall, pnack;
  logic [7:0] prb;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      eng_done = 1'b0;
      eng_cmd_ready = stall ? ~eng_cmd_ready : 1'b1;
      rd_ready = stall ? ~rd_ready : 1'b1;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          eng_done = 1'b1; eng_nack = pnack; eng_rbyte = prb;
        end
      end else if (eng_cmd_valid && eng_cmd_ready) begin
        if (log_n < 64) log_e[log_n] = {eng_op, eng_wbyte, (eng_op == 2'd3) ? eng_mack : 1'b0};
        log_n++;
        pend = 2; pnack = 1'b0;
        if (eng_op == 2'd2) begin pnack = nack_mask[wn]; wn++; end
        if (eng_op == 2'd3) begin prb = rd_base + 8'(rn); rn++; end
      end
      if (rd_valid && rd_ready) begin
        if (rd_n < 16) rd_got[rd_n] = rd_data;
        rd_n++;
      end
      wr_data = wsrc[wi % 8];
      if (wr_ready && wr_valid) wi++;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic e(input int op, input int b, input int ack);
    exp_e[exp_n] = {2'(op), 8'(b), 1'(ack)};
    exp_n++;
  endtask

  task automatic clear();
    log_n = 0; exp_n = 0; wn = 0; rn = 0; wi = 0; rd_n = 0; nack_mask = '0;
    stall = 1'b0; cfg_rep_start = 1'b0; cfg_ovf_en = 1'b0; cfg_ovf_mask = 3'd0;
  endtask

  task automatic check_log(input string tag);
    int bad = -1;
    for (int i = 0; i < exp_n; i++) if (bad < 0 && log_e[i] !== exp_e[i]) bad = i;
    chk(log_n == exp_n, {tag, " command count"}, log_n, exp_n);
    if (bad >= 0) chk(1'b0, {tag, " command sequence"}, int'(log_e[bad]), int'(exp_e[bad]));
    else chk(1'b1, tag, 0, 0);
  endtask

  task automatic run(input int op, input int dev, input int ra, input int alen, input int len);
    @(negedge clk);
    req_op = 2'(op); req_dev = 7'(dev); req_reg = 24'(ra);
    req_alen = 2'(alen); req_len = 8'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R12 busy after accept", req_ready, 0);
    while (done !== 1'b1) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(req_ready == 1 && eng_cmd_valid == 0 && rd_valid == 0 && done == 0, "R1 idle outputs",
        {req_ready, eng_cmd_valid, rd_valid, done}, 4'b1000);
    chk(status == 0 && fail_cnt == 0, "R1 result regs", {status, fail_cnt}, 0);
  endtask

  task automatic t_probe();
    clear(); run(0, 7'h3C, 0, 0, 0);
    e(S,0,0); e(W,8'h78,0); e(P,0,0);
    check_log("R2 probe ack"); chk(status == 0, "R2 present", status, 0);
    clear(); nack_mask[0] = 1'b1; run(3, 7'h11, 0, 0, 0);
    e(S,0,0); e(W,8'h22,0); e(P,0,0);
    check_log("R2 probe nack"); chk(status == 1, "R2 absent", status, 1);
  endtask

  task automatic t_read_ss();
    clear(); rd_base = 8'hC0;
    run(1, 7'h50, 24'hAB1234, 2, 3);  // R3: only low two bytes, MSB first
    e(S,0,0); e(W,8'hA0,0); e(W,8'h12,0); e(W,8'h34,0); e(P,0,0); e(S,0,0);
    e(W,8'hA1,0); e(R,0,1); e(R,0,1); e(R,0,0); e(P,0,0);
    check_log("R4 R6 read stop-start");
    chk(rd_n == 3 && rd_got[0] == 8'hC0 && rd_got[2] == 8'hC2, "R6 read data",
        {rd_got[0], rd_got[2]}, 16'hC0C2);
    chk(status == 0, "R6 status", status, 0);
  endtask

  task automatic t_read_rep();
    clear(); rd_base = 8'h5A; stall = 1'b1; cfg_rep_start = 1'b1;
    run(1, 7'h21, 24'h000077, 1, 1);
    e(S,0,0); e(W,8'h42,0); e(W,8'h77,0); e(S,0,0); e(W,8'h43,0); e(R,0,0); e(P,0,0);
    check_log("R4 R11 repeated start with stalls");
    chk(rd_n == 1 && rd_got[0] == 8'h5A, "R11 read byte under stall", rd_got[0], 8'h5A);
  endtask

  task automatic t_read_noaddr();
    clear(); rd_base = 8'h10;
    run(1, 7'h68, 24'hFFFFFF, 0, 2);  // R5
    e(S,0,0); e(W,8'hD1,0); e(R,0,1); e(R,0,0); e(P,0,0);
    check_log("R5 read without address phase");
    chk(rd_n == 2 && rd_got[1] == 8'h11, "R5 data", rd_got[1], 8'h11);
  endtask

  task automatic t_devnack();
    clear(); nack_mask[0] = 1'b1;
    run(1, 7'h33, 24'h000009, 1, 2);
    e(S,0,0); e(W,8'h66,0); e(P,0,0);
    check_log("R7 device nack"); chk(status == 1, "R7 status", status, 1);
  endtask

  task automatic t_regnack();
    clear(); nack_mask[2] = 1'b1;
    run(2, 7'h40, 24'hA1B2C3, 3, 2);
    e(S,0,0); e(W,8'h80,0); e(W,8'hA1,0); e(W,8'hB2,0); e(P,0,0);
    check_log("R8 R3 register nack"); chk(status == 2, "R8 status", status, 2);
  endtask

  task automatic t_write();
    clear(); nack_mask[3] = 1'b1; nack_mask[5] = 1'b1;
    for (int i = 0; i < 8; i++) wsrc[i] = 8'(8'h90 + i);
    run(2, 7'h2A, 24'h00003E, 1, 4);
    e(S,0,0); e(W,8'h54,0); e(W,8'h3E,0);
    e(W,8'h90,0); e(W,8'h91,0); e(W,8'h92,0); e(W,8'h93,0); e(P,0,0);
    check_log("R9 write continues past nack");
    chk(fail_cnt == 2 && status == 0, "R9 failure count", {status, fail_cnt}, 2);
    repeat (6) @(negedge clk);
    chk(fail_cnt == 2 && status == 0 && req_ready == 1, "R12 result held", fail_cnt, 2);
  endtask

  task automatic t_fold();
    clear(); cfg_ovf_en = 1'b1; cfg_ovf_mask = 3'b011; rd_base = 8'h01;
    run(1, 7'h50, 24'h0007A3, 1, 1);  // R10: upper bits 7 masked to 3
    e(S,0,0); e(W,8'hA6,0); e(W,8'hA3,0); e(P,0,0); e(S,0,0); e(W,8'hA7,0); e(R,0,0); e(P,0,0);
    check_log("R10 overflow fold read");
    clear(); cfg_ovf_en = 1'b1; cfg_ovf_mask = 3'b111;
    run(0, 7'h50, 24'h000007, 0, 0);
    e(S,0,0); e(W,8'hA0,0); e(P,0,0);
    check_log("R10 probe not folded");
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 0; req_dev = 0; req_reg = 0;
    req_alen = 0; req_len = 0; wr_valid = 1'b1; wr_data = 0; rd_ready = 1'b1;
    eng_cmd_ready = 1'b1; eng_done = 1'b0; eng_nack = 1'b0; eng_rbyte = 0;
    pend = 0; rd_base = 0; prb = 0; pnack = 0;
    for (int i = 0; i < 8; i++) wsrc[i] = 8'h00;
    clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_probe();
    t_read_ss();
    t_read_rep();
    t_read_noaddr();
    t_devnack();
    t_regnack();
    t_write();
    t_fold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 50000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=<50000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule